// File: doc/BRIEF.md
# Multiplexed Coefficient Register Loader

This block fills a filter's coefficient memory and its rounding and limit registers through one narrow 12-bit bus, clocked by its own load clock. Each transfer is five beats: an address word, then four data words. The address picks one of three register spaces. The first is a 256-entry coefficient memory, where each entry holds four 12-bit coefficients, one per bank. The second is sixteen 32-bit rounding registers. The third is sixteen limit registers, each holding a 16-bit upper bound and a 16-bit lower bound.

Loading runs only while the active-low enable is low. After reset, the loader stays inert until it has seen the enable go from high to low. Transfers can be chained back to back. A transfer aimed at an address outside the three spaces is consumed and dropped. Raising the enable cancels any partial transfer.

The filter datapath reads the stored values through dedicated ports:
- The coefficient memory has a registered read port indexed by set number.
- The rounding and limit registers are read combinationally through 4-bit selects.

Top module: `coef_loader`

## Requirements
- R1: While `ld_ni` is high, no bus word is captured and no coefficient, rounding or limit value changes, whatever `bus_i` carries.
- R2: The first word accepted after arming is an address and the next four words are data. The target is updated at the rising edge that captures the fourth data word, and it is still unchanged after the third.
- R3: After the fourth data word, the next accepted word is a new address, so transfers chain without raising `ld_ni`.
- R4: Addresses 0x000–0x0FF write coefficient set `addr[7:0]`, with data word k (k = 0..3) going to bank k. `coef_rdata_o[12k+11:12k]` returns bank k of set `coef_raddr_i` one clock after the address is applied.
- R5: Addresses 0x800–0x80F write rounding register `addr[3:0]`. The value is built from bits [7:0] of the data words, word 0 as the least significant byte and word 3 as the most significant byte. Bits [11:8] are dropped.
- R6: Addresses 0xC00–0xC0F write limit register `addr[3:0]`, packed the same way as R5. `lmt_upper_o` shows bits [31:16] and `lmt_lower_o` shows bits [15:0] of the register picked by `lmt_sel_i`.
- R7: Any other address (for example 0x100, 0x400, 0x810, 0x880, 0xC10) consumes its four data words and changes nothing, and the word after them is taken as an address.
- R8: After reset, words are ignored until a high-to-low transition of `ld_ni` has been seen at a clock edge. If `ld_ni` is held low straight out of reset, nothing loads.
- R9: Raising `ld_ni` in the middle of a transfer cancels it without a write, and the next accepted word is an address.
- R10: Reset clears all rounding and limit registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Load clock; all state updates on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_ni | input | 1 | Active-low load enable |
| bus_i | input | 12 | Multiplexed address/data word |
| coef_raddr_i | input | 8 | Coefficient set read index |
| coef_rdata_o | output | 48 | Four 12-bit coefficients of the read set, bank k at bits [12k+11:12k] |
| rnd_sel_i | input | 4 | Rounding register select |
| rnd_o | output | 32 | Selected rounding register |
| lmt_sel_i | input | 4 | Limit register select |
| lmt_upper_o | output | 16 | Upper limit of the selected limit register |
| lmt_lower_o | output | 16 | Lower limit of the selected limit register |

## Verification
The assertions assume three things:
- `ld_ni` and `bus_i` only change away from the rising edge of the load clock.
- A reset precedes all activity.
- The coefficient read port is never aimed at the set being written in that same cycle.

The stimulus respects these. Every input is driven on the falling edge. The coefficient memory is read only after the enable has been raised. Out of reset, the enable is first held low on purpose, to show the loader stays disarmed. It is then raised for one cycle so that a genuine falling edge arms it.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_COEF = 2'd1,
    TGT_RND  = 2'd2,
    TGT_LMT  = 2'd3
  } tgt_e;
endpackage

// File: rtl/cl_seq.sv
module cl_seq
  import cl_pkg::*;
#(
  parameter int              BUS_W    = 12,
  parameter int              N_BEATS  = 4,
  parameter int              SET_AW   = 8,
  parameter int              REG_AW   = 4,
  parameter logic [BUS_W-1:0] RND_BASE = 12'h800,
  parameter logic [BUS_W-1:0] LMT_BASE = 12'hC00
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ld_ni,
  input  logic [BUS_W-1:0]                bus_i,
  output logic                            wr_coef_o,
  output logic                            wr_rnd_o,
  output logic                            wr_lmt_o,
  output logic [SET_AW-1:0]               wr_idx_o,
  output logic [N_BEATS-1:0][BUS_W-1:0]   wr_words_o
);
  localparam int CNT_W = $clog2(N_BEATS + 1);

  logic                              ld_q, armed_q, accept, last;
  logic [CNT_W-1:0]                  beat_q;
  logic [BUS_W-1:0]                  addr_q;
  logic [N_BEATS-2:0][BUS_W-1:0]     words_q;
  tgt_e                              tgt;

  // arming: a low enable counts only once a high sample preceded it
  assign accept = !ld_ni && (armed_q || ld_q);
  assign last   = accept && (beat_q == CNT_W'(N_BEATS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q    <= 1'b0;
      armed_q <= 1'b0;
      beat_q  <= '0;
      addr_q  <= '0;
      words_q <= '0;
    end else begin
      ld_q <= ld_ni;
      if (ld_ni) begin
        beat_q <= '0;
      end else if (accept) begin
        armed_q <= 1'b1;
        if (beat_q == '0) addr_q <= bus_i;
        for (int k = 0; k < N_BEATS - 1; k++)
          if (beat_q == CNT_W'(k + 1)) words_q[k] <= bus_i;
        beat_q <= last ? '0 : beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    tgt = TGT_NONE;
    if (addr_q[BUS_W-1:SET_AW] == '0)                          tgt = TGT_COEF;
    else if (addr_q[BUS_W-1:REG_AW] == RND_BASE[BUS_W-1:REG_AW]) tgt = TGT_RND;
    else if (addr_q[BUS_W-1:REG_AW] == LMT_BASE[BUS_W-1:REG_AW]) tgt = TGT_LMT;
  end

  assign wr_coef_o = last && (tgt == TGT_COEF);
  assign wr_rnd_o  = last && (tgt == TGT_RND);
  assign wr_lmt_o  = last && (tgt == TGT_LMT);
  assign wr_idx_o  = addr_q[SET_AW-1:0];

  // final data word goes straight from the bus, no fifth staging register
  generate
    for (genvar k = 0; k < N_BEATS; k++) begin : g_words
      if (k < N_BEATS - 1) begin : g_held
        assign wr_words_o[k] = words_q[k];
      end else begin : g_live
        assign wr_words_o[k] = bus_i;
      end
    end
  endgenerate

  // R2
  beat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_q <= CNT_W'(N_BEATS));
  // R2
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_coef_o, wr_rnd_o, wr_lmt_o}));
  // R9
  abort_clears_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> (beat_q == '0));
  // R8
  beat_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_q != '0) |-> armed_q);
endmodule

// File: rtl/cl_regfile.sv
module cl_regfile #(
  parameter int AW = 4,
  parameter int W  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] rsel_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   regs_q         <= '0;
    else if (we_i) regs_q[widx_i] <= wdata_i;
  end

  assign rdata_o = regs_q[rsel_i];

  // R1
  hold_without_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/cl_coef_mem.sv
module cl_coef_mem #(
  parameter int N_BANKS = 4,
  parameter int BUS_W   = 12,
  parameter int SET_AW  = 8
) (
  input  logic                          clk_i,
  input  logic                          we_i,
  input  logic [SET_AW-1:0]             widx_i,
  input  logic [N_BANKS-1:0][BUS_W-1:0] wdata_i,
  input  logic [SET_AW-1:0]             raddr_i,
  output logic [N_BANKS-1:0][BUS_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << SET_AW;

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic [BUS_W-1:0] mem [DEPTH];
      logic [BUS_W-1:0] rd_q;

      always_ff @(posedge clk_i) begin
        if (we_i) mem[widx_i] <= wdata_i[b];
        rd_q <= mem[raddr_i];
      end

      assign rdata_o[b] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int              BUS_W    = 12,
  parameter int              N_BANKS  = 4,
  parameter int              SET_AW   = 8,
  parameter int              REG_AW   = 4,
  parameter int              REG_W    = 32,
  parameter logic [BUS_W-1:0] RND_BASE = 12'h800,
  parameter logic [BUS_W-1:0] LMT_BASE = 12'hC00
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_ni,
  input  logic [BUS_W-1:0]           bus_i,
  input  logic [SET_AW-1:0]          coef_raddr_i,
  output logic [N_BANKS*BUS_W-1:0]   coef_rdata_o,
  input  logic [REG_AW-1:0]          rnd_sel_i,
  output logic [REG_W-1:0]           rnd_o,
  input  logic [REG_AW-1:0]          lmt_sel_i,
  output logic [REG_W/2-1:0]         lmt_upper_o,
  output logic [REG_W/2-1:0]         lmt_lower_o
);
  localparam int BYTE_W = REG_W / N_BANKS;
  localparam int HALF_W = REG_W / 2;

  logic                          wr_coef, wr_rnd, wr_lmt;
  logic [SET_AW-1:0]             wr_idx;
  logic [N_BANKS-1:0][BUS_W-1:0] wr_words;
  logic [REG_W-1:0]              reg_wdata;
  logic [N_BANKS-1:0][BUS_W-1:0] coef_rd;
  logic [REG_W-1:0]              lmt_word;

  cl_seq #(
    .BUS_W(BUS_W), .N_BEATS(N_BANKS), .SET_AW(SET_AW), .REG_AW(REG_AW),
    .RND_BASE(RND_BASE), .LMT_BASE(LMT_BASE)
  ) u_seq (
    .clk_i, .rst_ni, .ld_ni, .bus_i,
    .wr_coef_o(wr_coef), .wr_rnd_o(wr_rnd), .wr_lmt_o(wr_lmt),
    .wr_idx_o(wr_idx), .wr_words_o(wr_words)
  );

  // low byte of each data word, word 0 least significant
  generate
    for (genvar k = 0; k < N_BANKS; k++) begin : g_pack
      assign reg_wdata[k*BYTE_W +: BYTE_W] = wr_words[k][BYTE_W-1:0];
    end
  endgenerate

  cl_coef_mem #(.N_BANKS(N_BANKS), .BUS_W(BUS_W), .SET_AW(SET_AW)) u_coef (
    .clk_i, .we_i(wr_coef), .widx_i(wr_idx), .wdata_i(wr_words),
    .raddr_i(coef_raddr_i), .rdata_o(coef_rd)
  );

  cl_regfile #(.AW(REG_AW), .W(REG_W)) u_rnd (
    .clk_i, .rst_ni, .we_i(wr_rnd), .widx_i(wr_idx[REG_AW-1:0]),
    .wdata_i(reg_wdata), .rsel_i(rnd_sel_i), .rdata_o(rnd_o)
  );

  cl_regfile #(.AW(REG_AW), .W(REG_W)) u_lmt (
    .clk_i, .rst_ni, .we_i(wr_lmt), .widx_i(wr_idx[REG_AW-1:0]),
    .wdata_i(reg_wdata), .rsel_i(lmt_sel_i), .rdata_o(lmt_word)
  );

  assign coef_rdata_o = coef_rd;
  assign lmt_upper_o  = lmt_word[REG_W-1:HALF_W];
  assign lmt_lower_o  = lmt_word[HALF_W-1:0];

  // R1
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |-> !(wr_coef || wr_rnd || wr_lmt));
endmodule

// File: tb/coef_loader_bench.sv
`timescale 1ns/1ps
module coef_loader_bench;
  localparam time CLK_P = 8ns;
  localparam int  NV    = 13;

  // {addr, d0, d1, d2, d3}
  localparam logic [59:0] VEC [NV] = '{
    {12'h000, 12'h111, 12'h222, 12'h333, 12'h444},
    {12'h0FF, 12'hABC, 12'hDEF, 12'h012, 12'h345},
    {12'h023, 12'h0A1, 12'h0B2, 12'h0C3, 12'h0D4},
    {12'h800, 12'hF11, 12'hE22, 12'hD33, 12'hC44},
    {12'h80F, 12'h078, 12'h056, 12'h034, 12'h012},
    {12'hC00, 12'h0CD, 12'h0AB, 12'h034, 12'h012},
    {12'hC0F, 12'h0FF, 12'h07F, 12'h000, 12'h080},
    {12'h400, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF},
    {12'h810, 12'h0AA, 12'h0AA, 12'h0AA, 12'h0AA},
    {12'hC10, 12'h055, 12'h055, 12'h055, 12'h055},
    {12'h123, 12'h777, 12'h777, 12'h777, 12'h777},
    {12'h880, 12'h099, 12'h099, 12'h099, 12'h099},
    {12'h080, 12'h800, 12'h801, 12'h802, 12'h803}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_n = 1'b0;
  logic [11:0] bus = '0;
  logic [7:0]  raddr = '0;
  logic [47:0] rdata;
  logic [3:0]  rsel = '0, lsel = '0;
  logic [31:0] rnd;
  logic [15:0] upper, lower;

  int checks = 0, failures = 0;
  logic [31:0] rnd_m [16];
  logic [31:0] lmt_m [16];
  logic [47:0] coef_m [256];

  always #(CLK_P/2) clk = ~clk;

  coef_loader u_coef_loader (
    .clk_i(clk), .rst_ni(rst_n), .ld_ni(ld_n), .bus_i(bus),
    .coef_raddr_i(raddr), .coef_rdata_o(rdata),
    .rnd_sel_i(rsel), .rnd_o(rnd),
    .lmt_sel_i(lsel), .lmt_upper_o(upper), .lmt_lower_o(lower)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic word(input logic [11:0] w);
    @(negedge clk); ld_n = 1'b0; bus = w;
  endtask

  task automatic idle();
    @(negedge clk); ld_n = 1'b1; bus = 12'h5A5;
  endtask

  task automatic xfer(input logic [59:0] v);
    word(v[59:48]); word(v[47:36]); word(v[35:24]); word(v[23:12]); word(v[11:0]);
  endtask

  function automatic logic [31:0] pack(input logic [59:0] v);
    return {v[7:0], v[19:12], v[31:24], v[43:36]};
  endfunction

  task automatic model(input logic [59:0] v);
    logic [11:0] a = v[59:48];
    if (a[11:8] == 4'h0)       coef_m[a[7:0]] = {v[11:0], v[23:12], v[35:24], v[47:36]};
    else if (a[11:4] == 8'h80) rnd_m[a[3:0]]  = pack(v);
    else if (a[11:4] == 8'hC0) lmt_m[a[3:0]]  = pack(v);
  endtask

  task automatic rd_rnd(input logic [3:0] s, output logic [31:0] v);
    rsel = s; #1 v = rnd;
  endtask

  task automatic rd_coef(input logic [7:0] a, output logic [47:0] v);
    @(negedge clk); raddr = a;
    @(negedge clk); #1 v = rdata;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [47:0] c;
    for (int i = 0; i < 16; i++) begin rnd_m[i] = '0; lmt_m[i] = '0; end

    // R10: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i += 5) begin
      rsel = 4'(i); lsel = 4'(i); #1;
      chk("R10 rnd reset", 64'(rnd), 64'h0);
      chk("R10 lmt reset", 64'({upper, lower}), 64'h0);
    end

    // R8: enable low straight out of reset never arms
    @(negedge clk); rst_n = 1'b1;
    xfer({12'h801, 12'h011, 12'h022, 12'h033, 12'h044});
    idle();
    rd_rnd(4'd1, r); chk("R8 no load before falling edge", 64'(r), 64'h0);

    // table: chained transfers, R3/R7 alignment
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i]);
      model(VEC[i]);
    end
    idle();
    for (int i = 0; i < 16; i++) begin
      rd_rnd(4'(i), r);
      chk("R5 rnd value", 64'(r), 64'(rnd_m[i]));
      lsel = 4'(i); #1;
      chk("R6 lmt upper", 64'(upper), 64'(lmt_m[i][31:16]));
      chk("R6 lmt lower", 64'(lower), 64'(lmt_m[i][15:0]));
    end
    rd_rnd(4'd0, r);  chk("R7 rnd0 not hit by 0x810", 64'(r), 64'h44332211);
    lsel = 4'd0; #1;  chk("R7 lmt0 not hit by 0xC10", 64'({upper, lower}), 64'h1234ABCD);
    lsel = 4'd15; #1; chk("R6 lmt15 halves", 64'({upper, lower}), 64'h80007FFF);
    rd_coef(8'h00, c); chk("R4 coef set 0", 64'(c), 64'(coef_m[0]));
    rd_coef(8'hFF, c); chk("R4 coef set 255", 64'(c), 64'(coef_m[255]));
    rd_coef(8'h23, c); chk("R7 coef set 0x23 not hit by 0x123", 64'(c), 64'h0D40C30B20A1);
    rd_coef(8'h80, c); chk("R3 last chained coef set", 64'(c), 64'h803802801800);
    // R4 one-cycle read latency
    @(negedge clk); raddr = 8'h00; #1;
    chk("R4 read not yet updated", 64'(rdata), 64'(coef_m[128]));
    @(negedge clk); #1;
    chk("R4 read after one clock", 64'(rdata), 64'h444333222111);

    // R2: write lands with the fourth data word
    word(12'h805); word(12'h001); word(12'h002); word(12'h003); word(12'h004);
    rd_rnd(4'd5, r); chk("R2 unchanged after third data", 64'(r), 64'h0);
    @(negedge clk); ld_n = 1'b1; #1;
    chk("R2 written with fourth data", 64'(rnd), 64'h04030201);

    // R1: enable high, bus busy
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ld_n = 1'b1; bus = (i % 2 == 0) ? 12'h805 : 12'h0EE;
    end
    rd_rnd(4'd5, r); chk("R1 idle bus ignored", 64'(r), 64'h04030201);
    rd_coef(8'h05, c);
    rd_coef(8'hEE, c);
    rd_rnd(4'd14, r); chk("R1 rnd14 untouched", 64'(r), 64'h0);

    // R9: abort mid-transfer
    word(12'h803); word(12'h0AA); word(12'h0BB);
    idle();
    xfer({12'h804, 12'h011, 12'h022, 12'h033, 12'h044});
    idle();
    rd_rnd(4'd3, r); chk("R9 aborted write dropped", 64'(r), 64'h0);
    rd_rnd(4'd4, r); chk("R9 next word is address", 64'(r), 64'h44332211);

    summary();
    $finish;
  end
endmodule